// File: doc/BRIEF.md
# Hamming Parity Accumulator for NAND Data Chunks

This block sits beside the byte path between a host and a NAND flash device. It builds single-error-correcting Hamming parity over each 256-byte chunk. Every byte with its valid strobe high, taken while the enable input is high, is folded into a running parity word. The same logic serves page programming and page reads, because it only watches bytes as they pass. When the last byte of a chunk is taken, the running parity is captured into a result word and a one-cycle valid pulse is raised. The next byte then starts a new chunk at once.

From each result the block derives the 24-bit code word kept in the spare area next to the chunk. It also sends that code out as three bytes, most significant byte first. A clear input drops the partial chunk and resets the count of completed chunks. Software uses the result to correct a single flipped bit on read, which it does by comparing the stored code with the recomputed code.

Top module: `hecc_chunk_parity`

## Requirements
- R1: After reset, `res_vld` and `code_vld` are 0, `res_word` is 0 and `chunk_cnt` is 0.
- R2: Result bits [5:0] hold the column parities over all bytes of the chunk, each the XOR of the selected data bits. Bit 0 covers bits {0,2,4,6}, bit 1 covers {1,3,5,7}, bit 2 covers {0,1,4,5}, bit 3 covers {2,3,6,7}, bit 4 covers {0..3} and bit 5 covers {4..7}.
- R3: Result bits from bit 6 upward hold the line parities. For byte-index bit k, bit 6+2k is the XOR of the byte parities of all bytes whose index has bit k clear. Bit 7+2k is the same XOR for the bytes whose index has bit k set. The first byte of a chunk has index 0.
- R4: When the 256th accepted byte of a chunk is taken, `res_word` shows that chunk's parity and `res_vld` is high for exactly the next cycle. `res_word` then holds its value until the next chunk completes.
- R5: There is no gap between chunks. The byte taken right after a chunk's last byte is index 0 of the next chunk, and its parity starts from zero.
- R6: A byte is taken only when `byte_vld` and `ecc_en` are both high in a cycle. Any other byte changes neither the parity nor the position in the chunk.
- R7: A cycle with `clr` high drops the running parity and the chunk position, sets `chunk_cnt` to 0 and stops any code output in progress. A byte offered in the same cycle is dropped.
- R8: `chunk_cnt` rises by one in the cycle in which `res_vld` is high.
- R9: `code_word` equals the bitwise inverse of (`res_word` shifted left by two), kept to 24 bits.
- R10: Starting the cycle after `res_vld`, `code_vld` is high for three cycles. During those cycles `code_byte` carries `code_word` bits [23:16], then [15:8], then [7:0].
- R11: A single flipped data bit between two otherwise equal chunks changes exactly one bit of each of the 11 even/odd parity pairs. The odd bits of the column pairs, read as a number, give the bit position. The odd bits of the line pairs, read as a number, give the byte index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Drop the partial chunk and reset the chunk count |
| ecc_en | input | 1 | Parity accumulation enable |
| byte_vld | input | 1 | A byte is on `byte_dat` this cycle |
| byte_dat | input | 8 | Data byte passing to or from the device |
| res_vld | output | 1 | One-cycle pulse when a chunk result is captured |
| res_word | output | 22 | Captured parity: column bits [5:0], line bits [21:6] |
| chunk_cnt | output | 16 | Number of chunks completed since the last clear |
| code_word | output | 24 | Spare-area code derived from `res_word` |
| code_vld | output | 1 | `code_byte` carries a code byte |
| code_byte | output | 8 | Code bytes, most significant first |

## Verification
Chunks are driven with all-zero data, with a single set bit at the first index and at the last index, and with dense pseudo-random data. Together these separate errors in the column groups from errors in the line even/odd pairing. One single-bit chunk is also compared against hand-computed values of the result and of the code. The stream is broken up with idle cycles, with bytes offered while disabled, and with a clear in the middle of a chunk, so that dropped or extra bytes show up as wrong results. Two chunks are run back to back to expose a lost or repeated byte at the boundary. A pair of chunks that differ in one bit is checked to decode back to that bit's byte index and bit position.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_IW = $clog2(BYTE_W);
   localparam int COL_W  = 2 * BIT_IW;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [COL_W-1:0]  colpar_t;

   // Each data bit feeds one parity of every even/odd pair, chosen by that
   // bit of its own position.
   function automatic colpar_t col_parity(input byte_t d);
      colpar_t c;
      c = '0;
      for (int b = 0; b < BYTE_W; b++) begin
         for (int l = 0; l < BIT_IW; l++) begin
            c[2*l + ((b >> l) & 1)] ^= d[b];
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/hecc_byte_term.sv
module hecc_byte_term
   import hecc_pkg::*;
#(
   parameter int IDXW = 8,
   localparam int RESW = COL_W + 2*IDXW
)(
   input  byte_t            dat,
   input  logic [IDXW-1:0]  idx,
   output logic [RESW-1:0]  term
);

   logic bpar;
   assign bpar = ^dat;

   assign term[COL_W-1:0] = col_parity(dat);

   for (genvar k = 0; k < IDXW; k++) begin : g_line
      assign term[COL_W + 2*k]     = bpar & ~idx[k];
      assign term[COL_W + 2*k + 1] = bpar &  idx[k];
   end

endmodule

// File: rtl/hecc_accum.sv
module hecc_accum
   import hecc_pkg::*;
#(
   parameter int CHUNK_BYTES = 256,
   parameter int CNT_W       = 16,
   localparam int IDXW = $clog2(CHUNK_BYTES),
   localparam int RESW = COL_W + 2*IDXW
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ecc_en,
   input  logic             byte_vld,
   input  byte_t            byte_dat,
   output logic [RESW-1:0]  res_word,
   output logic             res_vld,
   output logic [CNT_W-1:0] chunk_cnt
);

   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(CHUNK_BYTES - 1);

   if (CHUNK_BYTES < 2 || (CHUNK_BYTES & (CHUNK_BYTES - 1)) != 0) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a power of two of at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [IDXW-1:0] idx;
   logic [RESW-1:0] run, term, nxt;
   logic            take, last;

   hecc_byte_term #(.IDXW(IDXW)) u_term (
      .dat  (byte_dat),
      .idx  (idx),
      .term (term)
   );

   assign take = ecc_en & byte_vld;
   assign last = (idx == LAST_IDX);
   assign nxt  = run ^ term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= '0;
         idx       <= '0;
         res_word  <= '0;
         res_vld   <= 1'b0;
         chunk_cnt <= '0;
      end else begin
         res_vld <= 1'b0;
         if (clr) begin
            run       <= '0;
            idx       <= '0;
            chunk_cnt <= '0;
         end else if (take) begin
            idx <= idx + IDXW'(1);
            if (last) begin
               res_word  <= nxt;
               res_vld   <= 1'b1;
               run       <= '0;
               chunk_cnt <= chunk_cnt + CNT_W'(1);
            end else begin
               run <= nxt;
            end
         end
      end
   end

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> !res_vld);

   assert_pulse_follows_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> $past(take && !clr));

   assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !clr) |=> ($stable(run) && $stable(idx)));

   assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (run == '0 && idx == '0 && chunk_cnt == '0));

endmodule

// File: rtl/hecc_code_ser.sv
module hecc_code_ser
   import hecc_pkg::*;
#(
   parameter int RESW  = 22,
   parameter int CODEW = 24,
   localparam int CODE_BYTES = CODEW / BYTE_W,
   localparam int CBW        = $clog2(CODE_BYTES + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [RESW-1:0]  res_word,
   output logic [CODEW-1:0] code_word,
   output logic             code_vld,
   output byte_t            code_byte
);

   if (CODEW % BYTE_W != 0 || CODEW < RESW + 2) begin : g_bad_code
      $error("CODEW must be a whole number of bytes holding the result shifted by two");
   end

   logic [CODEW-1:0] sreg;
   logic [CBW-1:0]   left;

   assign code_word = ~(CODEW'(res_word) << 2);
   assign code_vld  = (left != '0);
   assign code_byte = sreg[CODEW-1 -: BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
      end else if (clr) begin
         left <= '0;
      end else if (load) begin
         sreg <= code_word;
         left <= CBW'(CODE_BYTES);
      end else if (left != '0) begin
         sreg <= sreg << BYTE_W;
         left <= left - CBW'(1);
      end
   end

   assert_code_starts_after_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(code_vld) |-> $past(load));

   assert_code_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (code_vld && !clr && !load) |=> (left == $past(left) - CBW'(1)));

endmodule

// File: rtl/hecc_chunk_parity.sv
module hecc_chunk_parity
   import hecc_pkg::*;
#(
   parameter int CHUNK_BYTES = 256,
   parameter int CNT_W       = 16,
   localparam int IDXW  = $clog2(CHUNK_BYTES),
   localparam int RESW  = COL_W + 2*IDXW,
   localparam int CODEW = ((RESW + 2 + BYTE_W - 1) / BYTE_W) * BYTE_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ecc_en,
   input  logic             byte_vld,
   input  logic [7:0]       byte_dat,
   output logic             res_vld,
   output logic [RESW-1:0]  res_word,
   output logic [CNT_W-1:0] chunk_cnt,
   output logic [CODEW-1:0] code_word,
   output logic             code_vld,
   output logic [7:0]       code_byte
);

   hecc_accum #(
      .CHUNK_BYTES (CHUNK_BYTES),
      .CNT_W       (CNT_W)
   ) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .ecc_en    (ecc_en),
      .byte_vld  (byte_vld),
      .byte_dat  (byte_dat),
      .res_word  (res_word),
      .res_vld   (res_vld),
      .chunk_cnt (chunk_cnt)
   );

   hecc_code_ser #(
      .RESW  (RESW),
      .CODEW (CODEW)
   ) u_code (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .load      (res_vld),
      .res_word  (res_word),
      .code_word (code_word),
      .code_vld  (code_vld),
      .code_byte (code_byte)
   );

   assert_count_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (chunk_cnt == CNT_W'($past(chunk_cnt) + 1)));

   assert_clear_stops_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!code_vld && !res_vld));

endmodule

// File: tb/tb_hecc_chunk_parity.sv
module tb_hecc_chunk_parity;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        ecc_en = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_dat = '0;
   logic        res_vld, code_vld;
   logic [21:0] res_word;
   logic [15:0] chunk_cnt;
   logic [23:0] code_word;
   logic [7:0]  code_byte;

   hecc_chunk_parity dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .ecc_en(ecc_en),
      .byte_vld(byte_vld), .byte_dat(byte_dat),
      .res_vld(res_vld), .res_word(res_word), .chunk_cnt(chunk_cnt),
      .code_word(code_word), .code_vld(code_vld), .code_byte(code_byte)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0]  chunk_buf [256];
   logic [7:0]  base [256];
   int          bidx = 0;
   logic [15:0] exp_cnt = '0;
   logic [21:0] res_q [$];
   logic [15:0] cnt_q [$];
   logic [7:0]  byte_q [$];
   logic [21:0] last_res = '0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reference built from the parity definitions in R2 and R3.
   function automatic logic [21:0] model();
      logic [21:0] r;
      logic [7:0]  m [6];
      m[0] = 8'h55; m[1] = 8'hAA; m[2] = 8'h33;
      m[3] = 8'hCC; m[4] = 8'h0F; m[5] = 8'hF0;
      r = '0;
      for (int i = 0; i < 256; i++) begin
         for (int c = 0; c < 6; c++) r[c] ^= ^(chunk_buf[i] & m[c]);
         for (int k = 0; k < 8; k++) begin
            if (i[k]) r[7 + 2*k] ^= ^chunk_buf[i];
            else      r[6 + 2*k] ^= ^chunk_buf[i];
         end
      end
      return r;
   endfunction

   task automatic finish_chunk();
      logic [21:0] r;
      logic [23:0] c;
      r = model();
      exp_cnt++;
      c = ~{r, 2'b00};
      res_q.push_back(r);
      cnt_q.push_back(exp_cnt);
      byte_q.push_back(c[23:16]);
      byte_q.push_back(c[15:8]);
      byte_q.push_back(c[7:0]);
   endtask

   task automatic drive(input logic [7:0] d, input logic en, input logic v);
      @(negedge clk);
      clr = 1'b0; ecc_en = en; byte_vld = v; byte_dat = d;
      if (en && v) begin
         chunk_buf[bidx] = d;
         bidx++;
         if (bidx == 256) begin
            finish_chunk();
            bidx = 0;
         end
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         byte_vld = 1'b0;
      end
   endtask

   // Monitor: pops expected items as the design produces them.
   always @(negedge clk) begin
      if (rst_n && res_vld) begin
         last_res = res_word;
         if (res_q.size() == 0) begin
            check("R4 unexpected result pulse", 32'd1, 32'd0);
         end else begin
            logic [21:0] er;
            er = res_q.pop_front();
            check("R2 R3 result word", 32'(res_word), 32'(er));
            check("R8 chunk count", 32'(chunk_cnt), 32'(cnt_q.pop_front()));
            check("R9 code word", 32'(code_word), 32'(~{er, 2'b00} & 24'hFFFFFF));
         end
      end
      if (rst_n && code_vld) begin
         if (byte_q.size() == 0) check("R10 unexpected code byte", 32'd1, 32'd0);
         else check("R10 code byte order", 32'(code_byte), 32'(byte_q.pop_front()));
      end
   end

   initial begin
      #(20 * 100000);
      check("watchdog expired", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 res_vld at reset", 32'(res_vld), 32'd0);
      check("R1 code_vld at reset", 32'(code_vld), 32'd0);
      check("R1 res_word at reset", 32'(res_word), 32'd0);
      check("R1 chunk_cnt at reset", 32'(chunk_cnt), 32'd0);
      rst_n = 1'b1;
      idle(2);

      // All-zero chunk.
      for (int i = 0; i < 256; i++) drive(8'h00, 1'b1, 1'b1);
      idle(8);

      // Single set bit at index 0: hand-computed values for R2, R3 and R9.
      drive(8'h01, 1'b1, 1'b1);
      for (int i = 1; i < 256; i++) drive(8'h00, 1'b1, 1'b1);
      idle(8);
      check("R2 R3 hand value bit0 idx0", 32'(res_word), 32'h155555);
      check("R9 hand code bit0 idx0", 32'(code_word), 32'hAAAAAB);
      check("R4 result held after pulse", 32'(res_vld), 32'd0);

      // Bit 7 at the last index.
      for (int i = 0; i < 255; i++) drive(8'h00, 1'b1, 1'b1);
      drive(8'h80, 1'b1, 1'b1);
      idle(8);

      // R6: random data with idle cycles and bytes offered while disabled.
      for (int i = 0; i < 256; i++) begin
         drive(8'((i * 37 + 11) ^ (i >> 3)), 1'b1, 1'b1);
         if (i % 7 == 0) drive(8'hFF, 1'b0, 1'b1);
         if (i % 11 == 0) drive(8'h3C, 1'b1, 1'b0);
      end
      idle(8);

      // R7: clear in mid chunk, with a byte offered in the same cycle.
      for (int i = 0; i < 100; i++) drive(8'(i * 5 + 1), 1'b1, 1'b1);
      @(negedge clk);
      clr = 1'b1; ecc_en = 1'b1; byte_vld = 1'b1; byte_dat = 8'hA5;
      @(negedge clk);
      clr = 1'b0; byte_vld = 1'b0;
      bidx = 0; exp_cnt = '0;
      check("R7 chunk_cnt cleared", 32'(chunk_cnt), 32'd0);
      for (int i = 0; i < 256; i++) drive(8'(i ^ 8'h5A), 1'b1, 1'b1);
      idle(8);
      check("R7 R8 count after clear", 32'(chunk_cnt), 32'd1);

      // R5: two chunks back to back, no gap.
      for (int i = 0; i < 512; i++) drive(8'((i * 13) ^ (i >> 2)), 1'b1, 1'b1);
      idle(8);
      check("R5 R8 count after back-to-back", 32'(chunk_cnt), 32'd3);

      // R11: one flipped bit (byte 77, bit 5).
      for (int i = 0; i < 256; i++) base[i] = 8'((i * 91 + 7) ^ (i >> 1));
      for (int i = 0; i < 256; i++) drive(base[i], 1'b1, 1'b1);
      idle(8);
      begin
         logic [21:0] r1, syn;
         r1 = last_res;
         for (int i = 0; i < 256; i++)
            drive((i == 77) ? (base[i] ^ 8'h20) : base[i], 1'b1, 1'b1);
         idle(8);
         syn = r1 ^ last_res;
         for (int p = 0; p < 11; p++)
            check("R11 one bit per pair", 32'(syn[2*p] ^ syn[2*p+1]), 32'd1);
         check("R11 bit position", 32'({syn[5], syn[3], syn[1]}), 32'd5);
         check("R11 byte index", 32'({syn[21], syn[19], syn[17], syn[15],
                                      syn[13], syn[11], syn[9], syn[7]}), 32'd77);
      end

      check("R4 all results seen", 32'(res_q.size()), 32'd0);
      check("R10 all code bytes seen", 32'(byte_q.size()), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule